// File: doc/BRIEF.md
# Dual-Source Loadable Serial Pixel Shifter

This block is a serial-out shift register for pixel streams. On every rising clock edge it either loads all of its stages from a two-way selector or shifts one place toward the output. One side of the selector takes a direct word. The other side takes a word that has passed through a holding stage. That stage can capture a word early, while the register is busy loading or shifting the other word. Software-free interleaving of two pixel words is therefore possible: capture the second word, load the first, shift it out, load the held second word, shift it out.

Only the last stage leaves the block. Wider shifters are built by feeding one block's serial output into the next block's serial input. The stage count is a parameter (default 8).

Top module: `pixshift_mux`

## Requirements
- R1: Driving `rst_n` low clears every stage and the held word at once, so `ser_out` reads 0. After release, a held-side load with the hold stage closed yields all zeros.
- R2: When `load_n` is 0 at a rising edge, every stage takes the selector output in one edge, and `ser_out` then shows bit WIDTH-1 of the loaded word.
- R3: When `load_n` is 1 at a rising edge, stage 0 takes `ser_in` and each stage n takes the previous value of stage n-1. The loaded word leaves most significant bit first, one bit per edge, and serial input bits leave in the order they entered.
- R4: With `sel_b` = 0 during a load, the register takes `a_word` whatever the level of `b_open`.
- R5: With `sel_b` = 1 and `b_open` = 0 during a load, the register takes the held word.
- R6: With `sel_b` = 1 and `b_open` = 1 during a load, the register takes the live `b_word` of that same edge.
- R7: The hold stage captures `b_word` on any edge where `b_open` = 1, whether the register is loading or shifting at that edge.
- R8: While `b_open` = 0, changes on `b_word` do not alter the held word.
- R9: Two blocks sharing controls, with the first block's `ser_out` wired to the second block's `ser_in`, shift out the 16-bit value {upper word, lower word} from the second block, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_n | input | 1 | 0: parallel load at the edge, 1: shift |
| sel_b | input | 1 | Load source: 0 direct word, 1 held-side word |
| b_open | input | 1 | 1: hold stage transparent and capturing, 0: holding |
| ser_in | input | 1 | Serial data into stage 0 |
| a_word | input | WIDTH | Direct parallel word |
| b_word | input | WIDTH | Parallel word into the hold stage |
| ser_out | output | 1 | Last stage (bit WIDTH-1) |

## Verification
The bench builds two copies with the default WIDTH of 8 and chains them. Eight stages keep every full shift-out short enough to compare whole words bit by bit. The chained pair brings the 16-bit cascade of R9 within reach. With the same width, the interleaved sequence of capture, direct load, shift and held load can be run with B data changing between steps.

// File: rtl/pixshift_pkg.sv
package pixshift_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned RST_SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    OP_SHIFT  = 2'd0,
    OP_LOAD_A = 2'd1,
    OP_LOAD_B = 2'd2
  } pix_op_e;
endpackage

// File: rtl/pixshift_bhold.sv
module pixshift_bhold #(
  parameter int unsigned WIDTH = pixshift_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] view_o,
  output logic [WIDTH-1:0] held_o
);
  logic [WIDTH-1:0] held_q;
  logic [WIDTH-1:0] held_d;
  logic             cap_en;

  // capture enable written out; bypass keeps transparent loads same-cycle
  always_comb begin
    cap_en = open_i;
    held_d = d_i;
    view_o = open_i ? d_i : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (cap_en) held_q <= held_d;
  end

  assign held_o = held_q;

  a_r8_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> held_q == $past(held_q));
  a_r7_capture_open: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |=> held_q == $past(d_i));
endmodule

// File: rtl/pixshift_select.sv
module pixshift_select #(
  parameter int unsigned WIDTH = pixshift_pkg::DEF_WIDTH
) (
  input  pixshift_pkg::pix_op_e op_i,
  input  logic [WIDTH-1:0]      a_i,
  input  logic [WIDTH-1:0]      b_i,
  output logic [WIDTH-1:0]      word_o
);
  always_comb begin
    unique case (op_i)
      pixshift_pkg::OP_LOAD_B: word_o = b_i;
      default:                 word_o = a_i;
    endcase
  end
endmodule

// File: rtl/pixshift_stages.sv
module pixshift_stages #(
  parameter int unsigned WIDTH = pixshift_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic [WIDTH-1:0] shifted;

  assign shifted[0] = ser_i;
  for (genvar i = 1; i <= LAST; i++) begin : g_link
    assign shifted[i] = stage_q[i-1];
  end

  always_comb begin
    stage_d = load_i ? word_i : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  a_r2_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> stage_q == $past(word_i));
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> stage_q[0] == $past(ser_i));
  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));
endmodule

// File: rtl/pixshift_mux.sv
module pixshift_mux #(
  parameter int unsigned WIDTH = pixshift_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             sel_b,
  input  logic             b_open,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  output logic             ser_out
);
  import pixshift_pkg::*;

  localparam int unsigned SYNC = RST_SYNC_DEPTH;

  logic [SYNC-1:0]  rst_pipe;
  logic             rst_q;
  pix_op_e          op;
  logic [WIDTH-1:0] b_view;
  logic [WIDTH-1:0] b_held;
  logic [WIDTH-1:0] ld_word;
  logic [WIDTH-1:0] stages;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC-1];

  always_comb begin
    if (load_n)     op = OP_SHIFT;
    else if (sel_b) op = OP_LOAD_B;
    else            op = OP_LOAD_A;
  end

  pixshift_bhold #(.WIDTH(WIDTH)) u_bhold (
    .clk    (clk),
    .rst_n  (rst_q),
    .open_i (b_open),
    .d_i    (b_word),
    .view_o (b_view),
    .held_o (b_held)
  );

  pixshift_select #(.WIDTH(WIDTH)) u_select (
    .op_i   (op),
    .a_i    (a_word),
    .b_i    (b_view),
    .word_o (ld_word)
  );

  pixshift_stages #(.WIDTH(WIDTH)) u_stages (
    .clk     (clk),
    .rst_n   (rst_q),
    .load_i  (op != OP_SHIFT),
    .word_i  (ld_word),
    .ser_i   (ser_in),
    .stage_o (stages)
  );

  assign ser_out = stages[WIDTH-1];

  a_r4_direct_load: assert property (@(posedge clk) disable iff (!rst_q)
    (!load_n && !sel_b) |=> stages == $past(a_word));
  a_r5_held_load: assert property (@(posedge clk) disable iff (!rst_q)
    (!load_n && sel_b && !b_open) |=> stages == $past(b_held));
  a_r6_live_load: assert property (@(posedge clk) disable iff (!rst_q)
    (!load_n && sel_b && b_open) |=> stages == $past(b_word));
  a_r3_out_follows: assert property (@(posedge clk) disable iff (!rst_q)
    load_n |=> ser_out == $past(stages[WIDTH-2]));
endmodule

// File: tb/pixshift_mux_bench.sv
module pixshift_mux_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, load_n, sel_b, b_open, ser_in;
  logic [W-1:0] a_word, b_word, a_hi, b_hi;
  logic ser_out, ser_out_hi;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pixshift_mux #(.WIDTH(W)) u_pixshift_mux (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .sel_b(sel_b), .b_open(b_open),
    .ser_in(ser_in), .a_word(a_word), .b_word(b_word), .ser_out(ser_out));

  pixshift_mux #(.WIDTH(W)) u_pixshift_mux_hi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .sel_b(sel_b), .b_open(b_open),
    .ser_in(ser_out), .a_word(a_hi), .b_word(b_hi), .ser_out(ser_out_hi));

  // mode bit (0 direct, 1 live held-side) and word
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h80}, {1'b1, 8'h01}};

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_load(input logic s, input logic o, input logic [W-1:0] a, input logic [W-1:0] b);
    sel_b = s; b_open = o; a_word = a; b_word = b; load_n = 1'b0;
    edge1();
    load_n = 1'b1; b_open = 1'b0;
  endtask

  task automatic read_out(output logic [W-1:0] v);
    load_n = 1'b1; b_open = 1'b0;
    v[W-1] = ser_out;
    for (int i = W - 2; i >= 0; i--) begin
      ser_in = 1'b0;
      edge1();
      v[i] = ser_out;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [2*W-1:0] v16;
    rst_n = 1'b0; load_n = 1'b1; sel_b = 1'b0; b_open = 1'b0; ser_in = 1'b0;
    a_word = '0; b_word = '0; a_hi = '0; b_hi = '0;
    repeat (3) edge1();
    rst_n = 1'b1;
    repeat (3) edge1();
    chk("R1 reset output", {15'd0, ser_out}, 16'd0);
    do_load(1'b1, 1'b0, 8'hFF, 8'hFF);
    read_out(v);
    chk("R1 held word cleared", {8'd0, v}, 16'd0);

    // table walk: R2 load, R3 order, R4 direct, R6 live
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] w;
      w = VEC[k][7:0];
      if (VEC[k][8]) do_load(1'b1, 1'b1, ~w, w);
      else           do_load(1'b0, 1'b1, w, ~w);
      chk("R2 first bit after load", {15'd0, ser_out}, {15'd0, w[W-1]});
      read_out(v);
      chk(VEC[k][8] ? "R6 live load" : "R4 direct load", {8'd0, v}, {8'd0, w});
    end

    // R7 capture during a shift, R8 hold, R5 held load
    b_word = 8'h5A; b_open = 1'b1; load_n = 1'b1;
    edge1();
    b_open = 1'b0; b_word = 8'hFF;
    edge1();
    do_load(1'b1, 1'b0, 8'h00, 8'hC7);
    read_out(v);
    chk("R5 R7 R8 held load", {8'd0, v}, 16'h005A);

    // R7 capture during direct load, R4 ignores open
    do_load(1'b0, 1'b1, 8'h81, 8'h3C);
    read_out(v);
    chk("R4 direct with open", {8'd0, v}, 16'h0081);
    do_load(1'b0, 1'b0, 8'h7E, 8'h99);
    read_out(v);
    chk("R4 direct with closed", {8'd0, v}, 16'h007E);
    do_load(1'b1, 1'b0, 8'h00, 8'h66);
    read_out(v);
    chk("R7 R8 captured at direct load", {8'd0, v}, 16'h003C);

    // R3 serial fill order
    begin
      logic [W-1:0] pat;
      pat = 8'hB2;
      load_n = 1'b1;
      for (int i = W - 1; i >= 0; i--) begin
        ser_in = pat[i];
        edge1();
      end
      read_out(v);
      chk("R3 serial in order", {8'd0, v}, {8'd0, pat});
    end

    // R9 chained 16-bit shift
    a_hi = 8'hA5;
    do_load(1'b0, 1'b0, 8'h0F, 8'h00);
    v16[2*W-1] = ser_out_hi;
    for (int i = 2 * W - 2; i >= 0; i--) begin
      ser_in = 1'b0;
      edge1();
      v16[i] = ser_out_hi;
    end
    chk("R9 chained word", v16, 16'hA50F);

    // R1 asynchronous clear mid-run
    do_load(1'b0, 1'b0, 8'hFF, 8'h00);
    chk("R1 preload", {15'd0, ser_out}, 16'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {15'd0, ser_out}, 16'd0);
    edge1();
    rst_n = 1'b1;
    repeat (3) edge1();
    do_load(1'b1, 1'b0, 8'h00, 8'hAA);
    read_out(v);
    chk("R1 held cleared mid-run", {8'd0, v}, 16'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule